// File: doc/BRIEF.md
# Integer ALU with Flag Register

This block is the arithmetic core of a small 32-bit processor datapath. It takes two operand words and a 4-bit function code and produces a result word with no register in that path. The same cycle's result is also used to compute three condition flags: signed overflow, zero and negative. These flags are captured into a flag register on the rising clock edge, but only when the caller asks for it.

Register-to-register arithmetic and logic instructions assert the flag-load input, so the flags reflect their outcome. The execute stage also uses the unit in its add mode for other sums: base plus displacement for an address, and stack-pointer plus 4 or plus −4. For that use it leaves the flag-load input low, so the flags keep the value from the last arithmetic instruction. Subtraction follows the destination-minus-source convention: the result is operand B minus operand A, because B names the register that receives the result.

Top module: `alu_cc_unit`

## Requirements
- R1: Function code 0 (add) drives `alu_out` with `opnd_b + opnd_a` modulo 2^32, in the same cycle as the inputs.
- R2: Function code 1 (subtract) drives `alu_out` with `opnd_b - opnd_a` modulo 2^32.
- R3: Function code 2 drives `alu_out` with the bitwise AND of the operands.
- R4: Function code 3 drives `alu_out` with the bitwise XOR of the operands.
- R5: When `cc_load` is 1 and the code is 0 to 3, the next rising edge sets `flag_zero` to 1 exactly when `alu_out` was zero, and sets `flag_neg` to bit 31 of `alu_out`.
- R6: For add with `cc_load` high, `flag_ov` becomes 1 exactly when the signed sum of the operands lies outside the range of a 32-bit two's-complement number.
- R7: For subtract with `cc_load` high, `flag_ov` becomes 1 exactly when the signed difference B − A lies outside the 32-bit two's-complement range.
- R8: AND and XOR with `cc_load` high clear `flag_ov`.
- R9: With `cc_load` low, all three flags keep their value across the clock edge, whatever the operands and the code.
- R10: Function codes 4 to 15 drive `alu_out` to zero and leave all three flags unchanged, even when `cc_load` is high.
- R11: A rising edge with `rst_n` low sets `flag_zero` to 1 and clears `flag_ov` and `flag_neg`. Reset has no effect on `alu_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flags load on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| opnd_a | input | 32 | Source operand (subtrahend for subtract) |
| opnd_b | input | 32 | Destination operand (minuend for subtract) |
| func | input | 4 | Function code: 0 add, 1 subtract, 2 AND, 3 XOR |
| cc_load | input | 1 | When high, the flags update at the next edge |
| alu_out | output | 32 | Combinational result |
| flag_ov | output | 1 | Registered signed overflow flag |
| flag_zero | output | 1 | Registered zero flag |
| flag_neg | output | 1 | Registered sign flag |

## Verification
The operand pairs sit on the signed-overflow boundary: 0x7fffffff + 1, 0x80000000 − 1, operands of opposite sign, and equal operands. These pairs show whether the overflow rule checks the sign of the right operand, and whether subtract has its operands the right way round. Wrap-around sums such as 0xffffffff + 1 must give zero without overflow, which separates the carry out from the signed overflow. Runs of random operands and codes, with `cc_load` toggling, show whether the flags hold during address arithmetic and whether unused codes are really ignored. Reset applied in the middle of a sequence shows whether the flags return to their reset values.

// File: rtl/alu_cc_pkg.sv
// Package for the integer ALU: function codes and the layout of the flag
// register. Assumes a 4-bit function field, with codes 0 to 3 defined.
package alu_cc_pkg;

    localparam int unsigned FUNC_W = 4;

    typedef enum logic [FUNC_W-1:0] {
        FN_ADD = 4'd0,
        FN_SUB = 4'd1,
        FN_AND = 4'd2,
        FN_XOR = 4'd3
    } alu_fn_e;

    typedef struct packed {
        logic ov;
        logic zf;
        logic sf;
    } alu_flags_t;

    localparam alu_flags_t FLAGS_RESET = '{ov: 1'b0, zf: 1'b1, sf: 1'b0};

    // True for the four defined codes.
    function automatic logic fn_defined(input logic [FUNC_W-1:0] code);
        return code[FUNC_W-1:2] == '0;
    endfunction

endpackage

// File: rtl/alu_cc_datapath.sv
// Combinational datapath. It computes the result and the raw flag values for
// one operation. Subtract gives B - A through a single shared adder. Assumes
// the function code is stable for the whole cycle. Undefined codes give zero.
module alu_cc_datapath
    import alu_cc_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0]  opnd_a,
    input  logic [WIDTH-1:0]  opnd_b,
    input  logic [FUNC_W-1:0] func,
    output logic [WIDTH-1:0]  result,
    output alu_flags_t        raw_flags
);
    localparam int unsigned MSB = WIDTH - 1;

    logic             is_sub;
    logic [WIDTH-1:0] addend;
    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] and_v;
    logic [WIDTH-1:0] xor_v;
    logic             ov_add;
    logic             ov_sub;

    // Shared adder: B + A, or B + ~A + 1 when subtracting.
    always_comb begin
        is_sub = (func == FN_SUB);
        addend = is_sub ? ~opnd_a : opnd_a;
        sum    = opnd_b + addend + WIDTH'(is_sub);
    end

    // Bitwise logic unit, one slice per bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign and_v[i] = opnd_a[i] & opnd_b[i];
        assign xor_v[i] = opnd_a[i] ^ opnd_b[i];
    end

    // Signed overflow for each arithmetic mode, judged against B's sign.
    always_comb begin
        ov_add = (opnd_a[MSB] == opnd_b[MSB]) && (sum[MSB] != opnd_b[MSB]);
        ov_sub = (opnd_a[MSB] != opnd_b[MSB]) && (sum[MSB] != opnd_b[MSB]);
    end

    // Select the result and the raw overflow by function code.
    always_comb begin
        result       = '0;
        raw_flags.ov = 1'b0;
        case (func)
            FN_ADD:  begin result = sum;   raw_flags.ov = ov_add; end
            FN_SUB:  begin result = sum;   raw_flags.ov = ov_sub; end
            FN_AND:  result = and_v;
            FN_XOR:  result = xor_v;
            default: result = '0;
        endcase
        raw_flags.zf = (result == '0);
        raw_flags.sf = result[MSB];
    end

    // Arithmetic results checked against their inverse operation.
    always_comb begin
        if (func == FN_ADD)
            AST_ADD_INVERSE: assert (result - opnd_b == opnd_a); // R1
        if (func == FN_SUB)
            AST_SUB_INVERSE: assert (result + opnd_a == opnd_b); // R2
        if (!fn_defined(func))
            AST_UNDEF_ZERO: assert (result == '0); // R10
    end

endmodule

// File: rtl/alu_cc_flagreg.sv
// Flag register. It loads the raw flags on a rising edge when loading is
// enabled and the code is defined; otherwise it holds. Synchronous reset,
// active low, to the zero-set state. Assumes load_en is driven in every cycle.
module alu_cc_flagreg
    import alu_cc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_en,
    input  alu_flags_t raw_flags,
    output alu_flags_t flags_q
);
    // Capture, hold or reset the flags.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= FLAGS_RESET;
        else if (load_en)
            flags_q <= raw_flags;
    end

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(flags_q)); // R9

    AST_RESET_VALUE: assert property (@(posedge clk)
        !rst_n |=> (flags_q == FLAGS_RESET)); // R11

endmodule

// File: rtl/alu_cc_unit.sv
// Top of the integer ALU. It joins the combinational datapath to the flag
// register. Flags load only for defined codes with cc_load high, so address
// and stack arithmetic run in add mode without touching the flags.
module alu_cc_unit
    import alu_cc_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  opnd_a,
    input  logic [WIDTH-1:0]  opnd_b,
    input  logic [FUNC_W-1:0] func,
    input  logic              cc_load,
    output logic [WIDTH-1:0]  alu_out,
    output logic              flag_ov,
    output logic              flag_zero,
    output logic              flag_neg
);
    alu_flags_t raw_flags;
    alu_flags_t flags_q;
    logic       load_en;

    alu_cc_datapath #(.WIDTH(WIDTH)) i_datapath (
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .func      (func),
        .result    (alu_out),
        .raw_flags (raw_flags)
    );

    // Gate the load: undefined codes never change the flags.
    assign load_en = cc_load && fn_defined(func);

    alu_cc_flagreg i_flagreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .raw_flags (raw_flags),
        .flags_q   (flags_q)
    );

    // Drive the flag outputs from the register.
    assign flag_ov   = flags_q.ov;
    assign flag_zero = flags_q.zf;
    assign flag_neg  = flags_q.sf;

    AST_ZERO_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (flag_zero == ($past(alu_out) == '0))); // R5

    AST_SIGN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (flag_neg == $past(alu_out[WIDTH-1]))); // R5

    AST_LOGIC_NO_OV: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_load && (func == FN_AND || func == FN_XOR)) |=> !flag_ov); // R8

    AST_UNDEF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !fn_defined(func) |=> $stable({flag_ov, flag_zero, flag_neg})); // R10

endmodule

// File: tb/test_alu_cc_unit.sv
`timescale 1ns/1ps
module test_alu_cc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [3:0]  func = '0;
    logic        cc_load = 1'b0;
    logic [31:0] alu_out;
    logic        flag_ov, flag_zero, flag_neg;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference flag state and the requirement behind each expected value.
    logic  m_ov = 1'b0, m_zf = 1'b1, m_sf = 1'b0;
    string t_zs = "R11", t_ov = "R11";

    always #2.5 clk = ~clk;

    alu_cc_unit i_alu_cc_unit (
        .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .func(func), .cc_load(cc_load), .alu_out(alu_out),
        .flag_ov(flag_ov), .flag_zero(flag_zero), .flag_neg(flag_neg)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One cycle: check the flags from the last edge, apply inputs, check the
    // result, then advance the reference model for the coming edge.
    task automatic step(input logic rst, input logic [31:0] a,
                        input logic [31:0] b, input logic [3:0] f,
                        input logic ld);
        logic [31:0] er;
        longint      s;
        string       rr;
        @(negedge clk);
        check(t_zs, "flag_zero", 32'(flag_zero), 32'(m_zf));
        check(t_zs, "flag_neg",  32'(flag_neg),  32'(m_sf));
        check(t_ov, "flag_ov",   32'(flag_ov),   32'(m_ov));
        rst_n = rst; opnd_a = a; opnd_b = b; func = f; cc_load = ld;
        #1;
        case (f)
            4'd0: begin er = b + a; rr = "R1"; s = longint'(signed'(b)) + longint'(signed'(a)); end
            4'd1: begin er = b - a; rr = "R2"; s = longint'(signed'(b)) - longint'(signed'(a)); end
            4'd2: begin er = b & a; rr = "R3"; s = 0; end
            4'd3: begin er = b ^ a; rr = "R4"; s = 0; end
            default: begin er = '0; rr = "R10"; s = 0; end
        endcase
        check(rr, "alu_out", alu_out, er);
        if (!rst) begin
            m_ov = 1'b0; m_zf = 1'b1; m_sf = 1'b0; t_zs = "R11"; t_ov = "R11";
        end else if (!ld) begin
            t_zs = "R9"; t_ov = "R9";
        end else if (f > 4'd3) begin
            t_zs = "R10"; t_ov = "R10";
        end else begin
            m_zf = (er == 0); m_sf = er[31]; t_zs = "R5";
            m_ov = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            t_ov = (f == 4'd0) ? "R6" : (f == 4'd1) ? "R7" : "R8";
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        step(1'b0, 32'h1, 32'h2, 4'd0, 1'b1);            // R11 reset
        step(1'b1, 32'h1, 32'h7fffffff, 4'd0, 1'b1);     // R6 overflow
        step(1'b1, 32'h1, 32'h80000000, 4'd1, 1'b1);     // R7 overflow
        step(1'b1, 32'h1, 32'hffffffff, 4'd0, 1'b1);     // R1 wrap, zero
        step(1'b1, 32'h12345678, 32'h12345678, 4'd1, 1'b1); // R2 equal
        step(1'b1, 32'h80000000, 32'h0, 4'd1, 1'b1);     // R7 0 - min
        step(1'b1, 32'hffffffff, 32'h1, 4'd1, 1'b1);     // R7 opposite signs
        step(1'b1, 32'h7fffffff, 32'h7fffffff, 4'd0, 1'b1); // R6 ov set
        step(1'b1, 32'hf0f0f0f0, 32'hff00ff00, 4'd2, 1'b1); // R8 clears ov
        step(1'b1, 32'h7fffffff, 32'h7fffffff, 4'd0, 1'b1); // R6 ov set
        step(1'b1, 32'haaaaaaaa, 32'haaaaaaaa, 4'd3, 1'b1); // R4 zero, R8
        step(1'b1, 32'h4, 32'h00000100, 4'd0, 1'b0);     // R9 stack add
        step(1'b1, 32'hfffffffc, 32'h0, 4'd0, 1'b0);     // R9
        step(1'b1, 32'h5, 32'h9, 4'd7, 1'b1);            // R10 undefined
        step(1'b1, 32'h5, 32'h9, 4'd15, 1'b1);           // R10
        step(1'b0, 32'h3, 32'h4, 4'd1, 1'b0);            // R11 mid-run
        step(1'b1, 32'h80000000, 32'h80000000, 4'd0, 1'b1); // R6 min+min
        for (int k = 0; k < 400; k++) begin
            logic [31:0] ra, rb;
            logic [3:0]  rf;
            ra = $urandom; rb = $urandom;
            if (k % 5 == 0) rb = ra;
            if (k % 7 == 0) ra = {ra[31], 31'h7fffffff};
            rf = ($urandom % 8 == 0) ? 4'($urandom) : 4'($urandom % 4);
            step(($urandom % 50) != 0, ra, rb, rf, $urandom % 3 != 0);
        end
        step(1'b1, 32'h0, 32'h0, 4'd0, 1'b0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #100000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule